// File: doc/BRIEF.md
# Partition Relocation and Block Key Guard

This unit sits between a simple processor's address generator and its memory. It checks every program address before that address reaches memory. Privileged system code loads three context registers when it dispatches a process: a partition start address, a partition length and a small access key. A separate write port fills a table that holds one protection code for each 2 KB block of physical memory.

For each request the unit does three things in one cycle. It compares the program offset against the partition length. It adds the start address to form the physical address. It looks up the code of the block that address falls in and compares that code with the running key. One cycle later it reports either a clean physical address or a trap with a cause. A write to the context registers from non-privileged code is dropped, and it is reported as a trap through the same response port.

Top module: `reloc_guard`

## Requirements
- R1: For a request that passes all checks, `rsp_paddr` equals the start register plus the zero-extended offset, modulo 2^PADDR_W (an overflowing sum wraps). `rsp_valid` is high for exactly the cycle after `req_valid`, and `rsp_trap` is low with `rsp_cause` = 0.
- R2: An offset greater than or equal to the length register traps with cause 1 (limit). An offset of length minus one passes the limit check. Any trapped response carries `rsp_paddr` = 0.
- R3: The block index is physical address bits [PADDR_W-1:11]. When the running key is non-zero and differs from that block's code, the request traps with cause 2 (key).
- R4: Key value 0 matches the code of every block.
- R5: When a request fails both the limit check and the key check, the reported cause is 1 (limit).
- R6: A privileged write (`cfg_priv`=1) with `cfg_sel` 0 loads the start register, 1 loads the length register and 2 loads the key from `cfg_wdata[3:0]`. Selector 3 changes nothing. A loaded value applies to requests from the next cycle on, and a request in the same cycle still uses the old value. A privileged write gives no response.
- R7: A write with `cfg_priv`=0 changes no register. One cycle later it produces `rsp_valid`=1, `rsp_trap`=1 and cause 3 (privilege). This cause overrides any fault of a request made in the same cycle.
- R8: A table write stores `tag_code` as the code of block `tag_blk`. The new code applies to requests from the next cycle on, and a table write gives no response.
- R9: Reset clears the start, length and key registers and every block code, and holds `rsp_valid` low. Any request after reset, before a length is loaded, traps with cause 1.
- R10: In a cycle with no request and no non-privileged write, the next cycle has `rsp_valid` and `rsp_trap` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Context register write strobe |
| cfg_priv | input | 1 | Writer is privileged |
| cfg_sel | input | 2 | Register selector: 0 start, 1 length, 2 key, 3 none |
| cfg_wdata | input | PADDR_W | Write data |
| tag_we | input | 1 | Protection table write strobe |
| tag_blk | input | PADDR_W-11 | Block index to write |
| tag_code | input | KEY_W | Protection code to store |
| req_valid | input | 1 | Access request strobe |
| req_offset | input | VADDR_W | Program-issued address |
| rsp_valid | output | 1 | Response present |
| rsp_trap | output | 1 | Response is a trap |
| rsp_cause | output | 2 | 0 none, 1 limit, 2 key, 3 privilege |
| rsp_paddr | output | PADDR_W | Physical address, 0 on trap |

## Verification
A table of offsets is run against one loaded partition. The offsets fall inside the first and middle blocks, just below and at the length, and at the top of the offset range. Together they separate clean translation, key mismatch and limit overflow, including an address that fails both checks. Directed cases then show the following:
- a start address that wraps past the top of physical memory;
- the master key turning a mismatch into a pass;
- table and register writes taking effect only from the next cycle;
- non-privileged writes that leave translation unchanged while the privilege cause wins over a fault in the same cycle.

// File: rtl/reloc_guard_pkg.sv
package reloc_guard_pkg;

   typedef enum logic [1:0] {
      CAUSE_NONE  = 2'd0,
      CAUSE_LIMIT = 2'd1,
      CAUSE_KEY   = 2'd2,
      CAUSE_PRIV  = 2'd3
   } cause_e;

   typedef enum logic [1:0] {
      SEL_START  = 2'd0,
      SEL_LENGTH = 2'd1,
      SEL_KEY    = 2'd2,
      SEL_NONE   = 2'd3
   } ctx_sel_e;

endpackage

// File: rtl/ctx_regs.sv
module ctx_regs
   import reloc_guard_pkg::*;
#(
   parameter int PADDR_W = 20,
   parameter int KEY_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic               cfg_priv,
   input  logic [1:0]         cfg_sel,
   input  logic [PADDR_W-1:0] cfg_wdata,
   output logic [PADDR_W-1:0] start_q,
   output logic [PADDR_W-1:0] length_q,
   output logic [KEY_W-1:0]   key_q,
   output logic               priv_err
);

   ctx_sel_e sel;
   logic     wr_ok;

   assign sel      = ctx_sel_e'(cfg_sel);
   assign wr_ok    = cfg_we & cfg_priv;
   assign priv_err = cfg_we & ~cfg_priv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q  <= '0;
         length_q <= '0;
         key_q    <= '0;
      end else if (wr_ok) begin
         case (sel)
            SEL_START:  start_q  <= cfg_wdata;
            SEL_LENGTH: length_q <= cfg_wdata;
            SEL_KEY:    key_q    <= cfg_wdata[KEY_W-1:0];
            default:    ;
         endcase
      end
   end

   // R7: blocked writes leave every context register untouched
   assert_blocked_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_priv) |=> ($stable(start_q) && $stable(length_q) && $stable(key_q)));

   // R6: a privileged start write lands one cycle later
   assert_start_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_priv && cfg_sel == SEL_START) |=> (start_q == $past(cfg_wdata)));

   // R6: selector 3 touches nothing
   assert_sel_none_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel == SEL_NONE) |=> ($stable(start_q) && $stable(length_q) && $stable(key_q)));

endmodule

// File: rtl/key_table.sv
module key_table #(
   parameter int PADDR_W     = 20,
   parameter int BLOCK_SHIFT = 11,
   parameter int KEY_W       = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         tag_we,
   input  logic [PADDR_W-BLOCK_SHIFT-1:0] tag_blk,
   input  logic [KEY_W-1:0]             tag_code,
   input  logic [PADDR_W-BLOCK_SHIFT-1:0] rd_blk,
   output logic [KEY_W-1:0]             rd_code
);

   localparam int BLK_W = PADDR_W - BLOCK_SHIFT;
   localparam int NBLK  = 1 << BLK_W;

   logic [KEY_W-1:0] code [NBLK];

   for (genvar g = 0; g < NBLK; g++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            code[g] <= '0;
         else if (tag_we && tag_blk == BLK_W'(g))
            code[g] <= tag_code;
      end
   end

   assign rd_code = code[rd_blk];

   // R8: table write is readable from the next cycle
   assert_tag_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tag_we |=> (code[$past(tag_blk)] == $past(tag_code)));

endmodule

// File: rtl/access_check.sv
module access_check
   import reloc_guard_pkg::*;
#(
   parameter int VADDR_W       = 16,
   parameter int PADDR_W       = 20,
   parameter int BLOCK_SHIFT   = 11,
   parameter int KEY_W         = 4,
   parameter bit MASTER_KEY_EN = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           req_valid,
   input  logic [VADDR_W-1:0]             req_offset,
   input  logic [PADDR_W-1:0]             start_q,
   input  logic [PADDR_W-1:0]             length_q,
   input  logic [KEY_W-1:0]               key_q,
   input  logic                           priv_err,
   input  logic [KEY_W-1:0]               blk_code,
   output logic [PADDR_W-BLOCK_SHIFT-1:0] lookup_blk,
   output logic                           rsp_valid,
   output logic                           rsp_trap,
   output logic [1:0]                     rsp_cause,
   output logic [PADDR_W-1:0]             rsp_paddr
);

   logic [PADDR_W-1:0] offset_ext;
   logic [PADDR_W-1:0] paddr_sum;
   logic               limit_hit;
   logic               key_ok;
   cause_e             cause_d;
   logic               trap_d;
   logic               valid_d;
   logic [PADDR_W-1:0] paddr_d;

   assign offset_ext = PADDR_W'(req_offset);
   assign paddr_sum  = start_q + offset_ext;
   assign limit_hit  = offset_ext >= length_q;
   assign lookup_blk = paddr_sum[PADDR_W-1:BLOCK_SHIFT];

   if (MASTER_KEY_EN) begin : g_master
      assign key_ok = (key_q == '0) || (key_q == blk_code);
   end else begin : g_strict
      assign key_ok = (key_q == blk_code);
   end

   always_comb begin
      cause_d = CAUSE_NONE;
      if (priv_err)
         cause_d = CAUSE_PRIV;
      else if (req_valid) begin
         if (limit_hit)
            cause_d = CAUSE_LIMIT;
         else if (!key_ok)
            cause_d = CAUSE_KEY;
      end
   end

   assign trap_d  = (cause_d != CAUSE_NONE);
   assign valid_d = req_valid | priv_err;
   assign paddr_d = (req_valid && !trap_d) ? paddr_sum : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_trap  <= 1'b0;
         rsp_cause <= CAUSE_NONE;
         rsp_paddr <= '0;
      end else begin
         rsp_valid <= valid_d;
         rsp_trap  <= trap_d;
         rsp_cause <= cause_d;
         rsp_paddr <= paddr_d;
      end
   end

   // R10: a response only follows a request or a blocked write
   assert_resp_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_valid && !priv_err) |=> (!rsp_valid && !rsp_trap));

   // R2: trapped responses never expose an address
   assert_trap_zero_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_trap |-> (rsp_paddr == '0 && rsp_valid));

   // R1: clean responses carry no cause
   assert_clean_no_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_trap) |-> (rsp_cause == CAUSE_NONE));

   // R7: privilege cause wins over any access fault
   assert_priv_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      priv_err |=> (rsp_trap && rsp_cause == CAUSE_PRIV));

   // R5: out-of-range offset always reports the limit cause
   assert_limit_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !priv_err && limit_hit) |=> (rsp_cause == CAUSE_LIMIT));

   if (MASTER_KEY_EN) begin : g_master_chk
      // R4: key zero never produces a key fault
      assert_master_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && key_q == '0) |=> (rsp_cause != CAUSE_KEY));
   end

endmodule

// File: rtl/reloc_guard.sv
module reloc_guard
   import reloc_guard_pkg::*;
#(
   parameter int VADDR_W       = 16,
   parameter int PADDR_W       = 20,
   parameter int BLOCK_SHIFT   = 11,
   parameter int KEY_W         = 4,
   parameter bit MASTER_KEY_EN = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           cfg_we,
   input  logic                           cfg_priv,
   input  logic [1:0]                     cfg_sel,
   input  logic [PADDR_W-1:0]             cfg_wdata,
   input  logic                           tag_we,
   input  logic [PADDR_W-BLOCK_SHIFT-1:0] tag_blk,
   input  logic [KEY_W-1:0]               tag_code,
   input  logic                           req_valid,
   input  logic [VADDR_W-1:0]             req_offset,
   output logic                           rsp_valid,
   output logic                           rsp_trap,
   output logic [1:0]                     rsp_cause,
   output logic [PADDR_W-1:0]             rsp_paddr
);

   localparam int BLK_W = PADDR_W - BLOCK_SHIFT;

   if (PADDR_W <= BLOCK_SHIFT) begin : g_bad_block
      $error("reloc_guard: PADDR_W must exceed BLOCK_SHIFT");
   end
   if (VADDR_W > PADDR_W) begin : g_bad_vaddr
      $error("reloc_guard: VADDR_W must not exceed PADDR_W");
   end
   if (KEY_W < 1 || KEY_W > PADDR_W) begin : g_bad_key
      $error("reloc_guard: KEY_W out of range");
   end
   if (BLK_W > 12) begin : g_bad_table
      $error("reloc_guard: protection table too large");
   end

   logic [PADDR_W-1:0] start_q;
   logic [PADDR_W-1:0] length_q;
   logic [KEY_W-1:0]   key_q;
   logic               priv_err;
   logic [BLK_W-1:0]   lookup_blk;
   logic [KEY_W-1:0]   blk_code;

   ctx_regs #(
      .PADDR_W (PADDR_W),
      .KEY_W   (KEY_W)
   ) i_ctx (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_priv  (cfg_priv),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .start_q   (start_q),
      .length_q  (length_q),
      .key_q     (key_q),
      .priv_err  (priv_err)
   );

   key_table #(
      .PADDR_W     (PADDR_W),
      .BLOCK_SHIFT (BLOCK_SHIFT),
      .KEY_W       (KEY_W)
   ) i_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .tag_we   (tag_we),
      .tag_blk  (tag_blk),
      .tag_code (tag_code),
      .rd_blk   (lookup_blk),
      .rd_code  (blk_code)
   );

   access_check #(
      .VADDR_W       (VADDR_W),
      .PADDR_W       (PADDR_W),
      .BLOCK_SHIFT   (BLOCK_SHIFT),
      .KEY_W         (KEY_W),
      .MASTER_KEY_EN (MASTER_KEY_EN)
   ) i_check (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_offset (req_offset),
      .start_q    (start_q),
      .length_q   (length_q),
      .key_q      (key_q),
      .priv_err   (priv_err),
      .blk_code   (blk_code),
      .lookup_blk (lookup_blk),
      .rsp_valid  (rsp_valid),
      .rsp_trap   (rsp_trap),
      .rsp_cause  (rsp_cause),
      .rsp_paddr  (rsp_paddr)
   );

   // R9: nothing is reported while held in reset
   assert_reset_quiet_R9: assert property (@(posedge clk)
      !rst_n |=> !rsp_valid);

endmodule

// File: tb/test_reloc_guard.sv
module test_reloc_guard;

   localparam int CLK_PERIOD = 10;
   localparam int VW = 16;
   localparam int PW = 20;
   localparam int BW = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic          cfg_priv = 1'b0;
   logic [1:0]    cfg_sel = '0;
   logic [PW-1:0] cfg_wdata = '0;
   logic          tag_we = 1'b0;
   logic [BW-1:0] tag_blk = '0;
   logic [3:0]    tag_code = '0;
   logic          req_valid = 1'b0;
   logic [VW-1:0] req_offset = '0;
   logic          rsp_valid;
   logic          rsp_trap;
   logic [1:0]    rsp_cause;
   logic [PW-1:0] rsp_paddr;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct packed {
      logic [15:0] off;
      logic [1:0]  cause;
      logic [19:0] paddr;
   } vec_t;

   localparam int NVEC = 9;
   localparam vec_t VECS [NVEC] = '{
      '{off: 16'h0000, cause: 2'd0, paddr: 20'h08000},
      '{off: 16'h07FF, cause: 2'd0, paddr: 20'h087FF},
      '{off: 16'h0800, cause: 2'd0, paddr: 20'h08800},
      '{off: 16'h0FFF, cause: 2'd0, paddr: 20'h08FFF},
      '{off: 16'h1000, cause: 2'd2, paddr: 20'h00000},
      '{off: 16'h17FF, cause: 2'd2, paddr: 20'h00000},
      '{off: 16'h1800, cause: 2'd1, paddr: 20'h00000},
      '{off: 16'hFFFF, cause: 2'd1, paddr: 20'h00000},
      '{off: 16'h0123, cause: 2'd0, paddr: 20'h08123}
   };

   reloc_guard i_reloc_guard (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_priv   (cfg_priv),
      .cfg_sel    (cfg_sel),
      .cfg_wdata  (cfg_wdata),
      .tag_we     (tag_we),
      .tag_blk    (tag_blk),
      .tag_code   (tag_code),
      .req_valid  (req_valid),
      .req_offset (req_offset),
      .rsp_valid  (rsp_valid),
      .rsp_trap   (rsp_trap),
      .rsp_cause  (rsp_cause),
      .rsp_paddr  (rsp_paddr)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic do_req(input logic [15:0] off, input logic [1:0] exp_cause,
                         input logic [19:0] exp_pa, input string tag);
      req_valid  = 1'b1;
      req_offset = off;
      @(negedge clk);
      check({tag, " valid"}, 32'(rsp_valid), 32'd1);
      check({tag, " trap"},  32'(rsp_trap),  32'(exp_cause != 2'd0));
      check({tag, " cause"}, 32'(rsp_cause), 32'(exp_cause));
      check({tag, " paddr"}, 32'(rsp_paddr), 32'(exp_pa));
      req_valid = 1'b0;
   endtask

   task automatic cfg_write(input logic priv, input logic [1:0] sel,
                            input logic [19:0] data, input string tag);
      cfg_we    = 1'b1;
      cfg_priv  = priv;
      cfg_sel   = sel;
      cfg_wdata = data;
      @(negedge clk);
      check({tag, " write valid"}, 32'(rsp_valid), 32'(!priv));
      if (!priv)
         check({tag, " write cause"}, 32'(rsp_cause), 32'd3);
      cfg_we = 1'b0;
   endtask

   task automatic tag_write(input logic [8:0] blk, input logic [3:0] code);
      tag_we   = 1'b1;
      tag_blk  = blk;
      tag_code = code;
      @(negedge clk);
      check("R8 table write gives no response", 32'(rsp_valid), 32'd0);
      tag_we = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset holds the response low
      check("R9 reset valid", 32'(rsp_valid), 32'd0);
      check("R9 reset trap",  32'(rsp_trap),  32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      do_req(16'h0000, 2'd1, 20'h0, "R9 zero length after reset");

      // R6: load partition start 0x08000, length 0x1800, key 5
      cfg_write(1'b1, 2'd0, 20'h08000, "R6 start");
      cfg_write(1'b1, 2'd1, 20'h01800, "R6 length");
      cfg_write(1'b1, 2'd2, 20'h00005, "R6 key");
      tag_write(9'd16, 4'd5);
      tag_write(9'd17, 4'd5);
      tag_write(9'd18, 4'd7);

      // R1/R2/R3/R5 table walk
      for (int i = 0; i < NVEC; i++)
         do_req(VECS[i].off, VECS[i].cause, VECS[i].paddr,
                $sformatf("R1/R2/R3/R5 vector %0d", i));

      // R8: retag block 18, then the edge offset passes
      tag_write(9'd18, 4'd5);
      do_req(16'h1000, 2'd0, 20'h09000, "R8 retagged block");
      do_req(16'h17FF, 2'd0, 20'h097FF, "R2 length minus one");

      // R7: blocked writes
      cfg_write(1'b0, 2'd0, 20'h00000, "R7 start");
      do_req(16'h0000, 2'd0, 20'h08000, "R7 start unchanged");
      cfg_write(1'b0, 2'd1, 20'hFFFFF, "R7 length");
      do_req(16'h1800, 2'd1, 20'h0, "R7 length unchanged");

      // R7: blocked write in the same cycle as a faulting request
      cfg_we = 1'b1; cfg_priv = 1'b0; cfg_sel = 2'd2; cfg_wdata = 20'h0;
      req_valid = 1'b1; req_offset = 16'hFFFF;
      @(negedge clk);
      check("R7 same-cycle valid", 32'(rsp_valid), 32'd1);
      check("R7 same-cycle cause", 32'(rsp_cause), 32'd3);
      check("R7 same-cycle paddr", 32'(rsp_paddr), 32'd0);
      cfg_we = 1'b0; req_valid = 1'b0;

      // R3 then R4: mismatched block, then master key
      tag_write(9'd17, 4'd9);
      do_req(16'h0800, 2'd2, 20'h0, "R3 key mismatch");
      cfg_write(1'b1, 2'd2, 20'h00000, "R4 key zero");
      do_req(16'h0800, 2'd0, 20'h08800, "R4 master key");

      // R6: selector 3 changes nothing
      cfg_write(1'b1, 2'd3, 20'h12345, "R6 sel none");
      do_req(16'h0000, 2'd0, 20'h08000, "R6 sel none no effect");

      // R1: wrap past the top of physical memory
      cfg_write(1'b1, 2'd0, 20'hFF800, "R1 start");
      cfg_write(1'b1, 2'd1, 20'h01000, "R1 length");
      do_req(16'h0900, 2'd0, 20'h00100, "R1 wrapped address");

      // R10: idle cycle
      @(negedge clk);
      check("R10 idle valid", 32'(rsp_valid), 32'd0);
      check("R10 idle trap",  32'(rsp_trap),  32'd0);

      // R6: request in the write cycle sees the old start
      cfg_we = 1'b1; cfg_priv = 1'b1; cfg_sel = 2'd0; cfg_wdata = 20'h10000;
      req_valid = 1'b1; req_offset = 16'h0000;
      @(negedge clk);
      check("R6 old start used", 32'(rsp_paddr), 32'hFF800);
      cfg_we = 1'b0; req_valid = 1'b0;
      do_req(16'h0000, 2'd0, 20'h10000, "R6 new start used");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule